// File: doc/BRIEF.md
# USB Device Interrupt Status Collector

This block gathers the device-level interrupt events of a USB device controller into a single read-only status word. Each event arrives as a one-cycle strobe and sets its own sticky bit. Software clears bits by writing ones to a clear port. Endpoint interrupts are split into a fast bit and a slow bit. A per-endpoint priority mask decides which of the two an endpoint feeds.

The block also keeps a need-clock flag. The flag rises on any activity on the USB data lines. It falls again once three 1 ms ticks pass with no frame in between. Its rising edge can produce a one-cycle wake request, but only when waking on bus activity is enabled.

The pending bits are ANDed with a per-bit enable mask and then ORed into one interrupt line. A global enable bit gates that line.

Top module: `usb_dev_irq_status`

## Requirements
- R1: After reset the status word reads 0x0000_0010: only the command-empty bit (bit 4) is 1. Bits 31:10 always read 0.
- R2: A frame strobe sets bit 0.
- R3: An endpoint strobe on endpoint i sets bit 1 (fast) when priority mask bit i is 1, and sets bit 2 (slow) when it is 0. Strobes on several endpoints in one cycle may set both bits.
- R4: Any one of the bus-reset, suspend-change or connect-change strobes sets bit 3.
- R5: The command-empty strobe sets bit 4 and the data-full strobe sets bit 5.
- R6: The receive end-of-packet strobe sets bit 6. The transmit end-of-packet strobe sets bit 7. The endpoint-realized strobe sets bit 8. The endpoint-related strobe sets bit 9.
- R7: With the clear-write strobe high, each 1 in clear-data bits 9:0 clears that status bit on the next edge. A bit whose set strobe is high in the same cycle stays at 1. Zeros in the clear data leave their bits unchanged.
- R8: A bus-activity strobe sets the need-clock output on the next edge.
- R9: The need-clock output clears on the third ms tick counted while it is 1. A frame or bus-activity strobe restarts the count, and wins over a tick that arrives in the same cycle.
- R10: The wake request is high for exactly the one cycle in which need-clock first reads 1, and only if the wake-enable input was 1 in the setting cycle.
- R11: The interrupt output equals the global enable AND the OR of (status AND enable mask). The global enable resets to 1 and takes the write data on the next edge when its write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEvt | input | 1 | Frame strobe |
| epEvt | input | NUM_EP | Per-endpoint interrupt strobes |
| epPrioMask | input | NUM_EP | 1 routes the endpoint to the fast bit |
| busResetEvt | input | 1 | Bus reset strobe |
| suspendChgEvt | input | 1 | Suspend-state change strobe |
| connectChgEvt | input | 1 | Connect-state change strobe |
| cmdEmptyEvt | input | 1 | Command register emptied strobe |
| dataFullEvt | input | 1 | Command data ready strobe |
| rxEndEvt | input | 1 | Receive end-of-packet strobe |
| txEndEvt | input | 1 | Transmit end-of-packet strobe |
| epRealizedEvt | input | 1 | Endpoint realized strobe |
| epRelatedEvt | input | 1 | Endpoint-related interrupt strobe |
| busActivity | input | 1 | Activity or state change on the data lines |
| msTick | input | 1 | 1 ms tick |
| busWakeEn | input | 1 | Allow bus activity to raise a wake request |
| clrWe | input | 1 | Clear-write strobe |
| clrData | input | 32 | Write-one-to-clear data |
| intEnMask | input | 10 | Per-bit interrupt enable |
| globalEnWe | input | 1 | Global enable write strobe |
| globalEnData | input | 1 | Global enable write value |
| statusOut | output | 32 | Read-only status word |
| needClock | output | 1 | Need-clock flag |
| wakeReq | output | 1 | One-cycle wake request |
| globalEn | output | 1 | Current global enable |
| irqOut | output | 1 | Combined interrupt line |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a set strobe and a write-one-to-clear aimed at the same bit. The bench drives both in one cycle and expects the bit to stay at 1, while a bit cleared alone in that same write falls. The second pair is a ms tick and a frame strobe on the need-clock timer. The bench sends the two together after two idle ticks and expects the flag to survive three more ticks before it clears. Every cycle's status word, need-clock, wake and interrupt outputs are compared against a model built from the requirements.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int STAT_BITS = 10;
  localparam int B_FRAME = 0;
  localparam int B_FAST = 1;
  localparam int B_SLOW = 2;
  localparam int B_DEV = 3;
  localparam int B_CMDEMPTY = 4;
  localparam int B_DATAFULL = 5;
  localparam int B_RXEND = 6;
  localparam int B_TXEND = 7;
  localparam int B_REALIZED = 8;
  localparam int B_EPREL = 9;
  localparam logic [STAT_BITS-1:0] STAT_RESET = STAT_BITS'(1 << B_CMDEMPTY);

  typedef struct packed {
    logic [STAT_BITS-1:0] setVec;
    logic [STAT_BITS-1:0] clrVec;
    logic enWe;
    logic enData;
  } irq_strobe_t;
endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int REG_W = 32,
  parameter int RELEASE_MS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameEvt,
  input  logic [NUM_EP-1:0] epEvt,
  input  logic [NUM_EP-1:0] epPrioMask,
  input  logic              busResetEvt,
  input  logic              suspendChgEvt,
  input  logic              connectChgEvt,
  input  logic              cmdEmptyEvt,
  input  logic              dataFullEvt,
  input  logic              rxEndEvt,
  input  logic              txEndEvt,
  input  logic              epRealizedEvt,
  input  logic              epRelatedEvt,
  input  logic              busActivity,
  input  logic              msTick,
  input  logic              busWakeEn,
  input  logic              clrWe,
  input  logic [REG_W-1:0]  clrData,
  input  logic              globalEnWe,
  input  logic              globalEnData,
  output irq_strobe_t       strobes,
  output logic              needClock,
  output logic              wakeReq
);
  localparam int CNT_W = $clog2(RELEASE_MS + 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(RELEASE_MS - 1);

  logic fastHit, slowHit;
  logic [CNT_W-1:0] msCount;
  logic restart;

  // Endpoint steering: the priority mask picks the fast or the slow line.
  always_comb begin
    fastHit = 1'b0;
    slowHit = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (epEvt[i]) begin
        if (epPrioMask[i]) fastHit = 1'b1;
        else               slowHit = 1'b1;
      end
    end
  end

  always_comb begin
    strobes = '0;
    strobes.setVec[B_FRAME]    = frameEvt;
    strobes.setVec[B_FAST]     = fastHit;
    strobes.setVec[B_SLOW]     = slowHit;
    strobes.setVec[B_DEV]      = busResetEvt | suspendChgEvt | connectChgEvt;
    strobes.setVec[B_CMDEMPTY] = cmdEmptyEvt;
    strobes.setVec[B_DATAFULL] = dataFullEvt;
    strobes.setVec[B_RXEND]    = rxEndEvt;
    strobes.setVec[B_TXEND]    = txEndEvt;
    strobes.setVec[B_REALIZED] = epRealizedEvt;
    strobes.setVec[B_EPREL]    = epRelatedEvt;
    strobes.clrVec = clrWe ? clrData[STAT_BITS-1:0] : '0;
    strobes.enWe   = globalEnWe;
    strobes.enData = globalEnData;
  end

  // Need-clock timer: activity or a frame restarts the ms count.
  assign restart = busActivity | frameEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      needClock <= 1'b0;
      msCount   <= '0;
      wakeReq   <= 1'b0;
    end else begin
      wakeReq <= busActivity & ~needClock & busWakeEn;
      if (busActivity) needClock <= 1'b1;
      if (restart) begin
        msCount <= '0;
      end else if (msTick && needClock) begin
        if (msCount == LAST_TICK) begin
          needClock <= 1'b0;
          msCount   <= '0;
        end else begin
          msCount <= msCount + 1'b1;
        end
      end
    end
  end

  p_set_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    busActivity |=> needClock);
  p_wake_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $rose(needClock));
  p_release_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(needClock) |-> ($past(msTick) && !$past(frameEvt)));
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    msCount <= LAST_TICK);
endmodule

// File: rtl/usb_irq_dp.sv
module usb_irq_dp
  import usb_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irq_strobe_t          strobes,
  input  logic [STAT_BITS-1:0] intEnMask,
  output logic [REG_W-1:0]     statusOut,
  output logic                 globalEn,
  output logic                 irqOut
);
  logic [STAT_BITS-1:0] statusReg;

  // Each status bit is sticky; a set in the same cycle beats a clear.
  generate
    for (genvar b = 0; b < STAT_BITS; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rstN)                  statusReg[b] <= STAT_RESET[b];
        else if (strobes.setVec[b]) statusReg[b] <= 1'b1;
        else if (strobes.clrVec[b]) statusReg[b] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             globalEn <= 1'b1;
    else if (strobes.enWe) globalEn <= strobes.enData;
  end

  assign statusOut = {{(REG_W-STAT_BITS){1'b0}}, statusReg};
  assign irqOut = globalEn & (|(statusReg & intEnMask));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.setVec) |=> ((statusReg & $past(strobes.setVec)) == $past(strobes.setVec)));
  p_clear_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobes.clrVec & ~strobes.setVec)) |=>
      ((statusReg & $past(strobes.clrVec & ~strobes.setVec)) == '0));
  p_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqOut);
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int REG_W = 32,
  parameter int RELEASE_MS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameEvt,
  input  logic [NUM_EP-1:0] epEvt,
  input  logic [NUM_EP-1:0] epPrioMask,
  input  logic              busResetEvt,
  input  logic              suspendChgEvt,
  input  logic              connectChgEvt,
  input  logic              cmdEmptyEvt,
  input  logic              dataFullEvt,
  input  logic              rxEndEvt,
  input  logic              txEndEvt,
  input  logic              epRealizedEvt,
  input  logic              epRelatedEvt,
  input  logic              busActivity,
  input  logic              msTick,
  input  logic              busWakeEn,
  input  logic              clrWe,
  input  logic [REG_W-1:0]  clrData,
  input  logic [9:0]        intEnMask,
  input  logic              globalEnWe,
  input  logic              globalEnData,
  output logic [REG_W-1:0]  statusOut,
  output logic              needClock,
  output logic              wakeReq,
  output logic              globalEn,
  output logic              irqOut
);
  irq_strobe_t strobes;

  usb_irq_ctrl #(.NUM_EP(NUM_EP), .REG_W(REG_W), .RELEASE_MS(RELEASE_MS)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameEvt(frameEvt), .epEvt(epEvt),
    .epPrioMask(epPrioMask), .busResetEvt(busResetEvt),
    .suspendChgEvt(suspendChgEvt), .connectChgEvt(connectChgEvt),
    .cmdEmptyEvt(cmdEmptyEvt), .dataFullEvt(dataFullEvt),
    .rxEndEvt(rxEndEvt), .txEndEvt(txEndEvt),
    .epRealizedEvt(epRealizedEvt), .epRelatedEvt(epRelatedEvt),
    .busActivity(busActivity), .msTick(msTick), .busWakeEn(busWakeEn),
    .clrWe(clrWe), .clrData(clrData), .globalEnWe(globalEnWe),
    .globalEnData(globalEnData), .strobes(strobes),
    .needClock(needClock), .wakeReq(wakeReq)
  );

  usb_irq_dp #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .intEnMask(intEnMask),
    .statusOut(statusOut), .globalEn(globalEn), .irqOut(irqOut)
  );

  p_high_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[REG_W-1:STAT_BITS] == '0);
  p_fast_route_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(epEvt & epPrioMask)) |=> statusOut[B_FAST]);
  p_slow_route_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(epEvt & ~epPrioMask)) |=> statusOut[B_SLOW]);
  p_dev_stat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busResetEvt | suspendChgEvt | connectChgEvt) |=> statusOut[B_DEV]);
endmodule

// File: tb/usb_dev_irq_status_tb.sv
module usb_dev_irq_status_tb_top;
  localparam int NEP = 4;

  logic clk = 0, rstN = 0;
  logic frameEvt = 0, busResetEvt = 0, suspendChgEvt = 0, connectChgEvt = 0;
  logic cmdEmptyEvt = 0, dataFullEvt = 0, rxEndEvt = 0, txEndEvt = 0;
  logic epRealizedEvt = 0, epRelatedEvt = 0, busActivity = 0, msTick = 0;
  logic busWakeEn = 0, clrWe = 0, globalEnWe = 0, globalEnData = 0;
  logic [NEP-1:0] epEvt = '0, epPrioMask = '0;
  logic [31:0] clrData = '0;
  logic [9:0] intEnMask = '0;
  logic [31:0] statusOut;
  logic needClock, wakeReq, globalEn, irqOut;

  always #5 clk = ~clk;

  usb_dev_irq_status dut_i (.*);

  typedef struct {
    logic [31:0] st;
    logic nc, wk, irq;
    string tag;
  } exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0;
  logic [9:0] mStat;
  logic mNc, mEn;
  int mCnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: inputs are already set; update the model, queue the expectation, pass one edge.
  task automatic step(input string tag);
    exp_t e;
    logic [9:0] setV;
    logic wk;
    setV = '0;
    setV[0] = frameEvt;
    setV[1] = |(epEvt & epPrioMask);
    setV[2] = |(epEvt & ~epPrioMask);
    setV[3] = busResetEvt | suspendChgEvt | connectChgEvt;
    setV[4] = cmdEmptyEvt; setV[5] = dataFullEvt;
    setV[6] = rxEndEvt; setV[7] = txEndEvt;
    setV[8] = epRealizedEvt; setV[9] = epRelatedEvt;
    mStat = (mStat & ~(clrWe ? clrData[9:0] : 10'h0)) | setV;
    wk = 1'b0;
    if (busActivity) begin
      wk = !mNc && busWakeEn; mNc = 1'b1; mCnt = 0;
    end else if (frameEvt) mCnt = 0;
    else if (msTick && mNc) begin
      if (mCnt == 2) begin mNc = 1'b0; mCnt = 0; end else mCnt++;
    end
    if (globalEnWe) mEn = globalEnData;
    e.st = {22'h0, mStat}; e.nc = mNc; e.wk = wk;
    e.irq = mEn & (|(mStat & intEnMask)); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    frameEvt = 0; epEvt = '0; busResetEvt = 0; suspendChgEvt = 0; connectChgEvt = 0;
    cmdEmptyEvt = 0; dataFullEvt = 0; rxEndEvt = 0; txEndEvt = 0;
    epRealizedEvt = 0; epRelatedEvt = 0; busActivity = 0; msTick = 0;
    clrWe = 0; clrData = '0; globalEnWe = 0;
  endtask

  task automatic clearAll();
    clrWe = 1; clrData = 32'hFFFF_FFFF; step("R7 clear all");
  endtask

  // Monitor: compare after each edge against the queued expectation.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rstN && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " status"}, statusOut, e.st);
        chk({e.tag, " needClock"}, {31'h0, needClock}, {31'h0, e.nc});
        chk({e.tag, " wakeReq"}, {31'h0, wakeReq}, {31'h0, e.wk});
        chk({e.tag, " irqOut"}, {31'h0, irqOut}, {31'h0, e.irq});
      end
    end
  end

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    mStat = 10'h010; mNc = 0; mEn = 1; mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(posedge clk); #2;
    chk("R1 reset status", statusOut, 32'h0000_0010);
    chk("R11 reset globalEn", {31'h0, globalEn}, 32'h1);
    chk("R8 reset needClock", {31'h0, needClock}, 32'h0);
    @(negedge clk);

    frameEvt = 1; step("R2 frame");
    clearAll();
    epEvt = 4'b0001; epPrioMask = 4'b0001; step("R3 fast");
    epEvt = 4'b0010; step("R3 slow");
    clearAll();
    epEvt = 4'b0110; epPrioMask = 4'b0100; step("R3 both");
    clearAll();
    busResetEvt = 1; step("R4 bus reset");
    clearAll();
    suspendChgEvt = 1; step("R4 suspend");
    clearAll();
    connectChgEvt = 1; step("R4 connect");
    clearAll();
    cmdEmptyEvt = 1; step("R5 cmd empty");
    dataFullEvt = 1; step("R5 data full");
    rxEndEvt = 1; step("R6 rx end");
    txEndEvt = 1; step("R6 tx end");
    epRealizedEvt = 1; step("R6 realized");
    epRelatedEvt = 1; step("R6 ep related");
    rxEndEvt = 1; clrWe = 1; clrData = 32'h0000_00C0; step("R7 set wins");
    clrWe = 1; clrData = 32'h0; step("R7 zero clear no effect");
    clrWe = 1; clrData = 32'h0000_0030; step("R7 clear two bits");
    clearAll();

    busWakeEn = 0; busActivity = 1; step("R8 activity no wake");
    step("R10 idle");
    repeat (2) begin msTick = 1; step("R9 tick"); end
    frameEvt = 1; msTick = 1; step("R9 frame beats tick");
    repeat (3) begin msTick = 1; step("R9 tick to release"); end
    step("R9 released");
    clearAll();
    busWakeEn = 1; busActivity = 1; step("R10 wake");
    step("R10 wake one cycle");
    busActivity = 1; step("R10 no wake when already set");
    repeat (3) begin msTick = 1; step("R9 release"); end
    clearAll();

    intEnMask = 10'h008; busResetEvt = 1; step("R11 irq on");
    globalEnWe = 1; globalEnData = 0; step("R11 global off");
    suspendChgEvt = 1; step("R11 gated");
    globalEnWe = 1; globalEnData = 1; step("R11 global on");
    intEnMask = 10'h001; step("R11 mask off");
    frameEvt = 1; step("R11 other bit");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule